// File: doc/BRIEF.md
# Paired-Address Video Mode Switch Bank

This block holds the single-bit display and memory mode flags of a legacy video and memory controller. Each flag is driven by touching one of two neighbouring I/O addresses: the low address bit gives the new value, so software changes a mode with one access and no data. Some pairs respond to any access, some respond only to writes, and one flag (annunciator 3) is stored with inverted sense. Each readable flag can be read back in bit 7 at its own status address, which sits in a separate address range. A write to the memory-state register also sets the page-2 flag.

The host presents an address, a write strobe, an access-valid strobe and write data for one cycle per access. The read data and a slow-access flag are combinational in the same cycle and come from the flag state before the access. A flag change takes effect on the clock edge that ends the access. The flag outputs feed the video generator, which is outside this block.

Top module: `vmode_switch_bank`

## Requirements
- R1: After reset all eight flags are 0. With no valid access, rdata_o is 0x00 and slow_o is 0.
- R2: A read or a write to page C0, offsets 0x50–0x57, loads address bit 0 into one flag. Address bits 2:1 choose the flag: 0 text, 1 mixed, 2 page 2, 3 high resolution. The new value shows on the outputs from the next cycle.
- R3: A read or a write to offsets 0x5E/0x5F loads annunciator 3 with the inverse of address bit 0. So 0x5E sets it and 0x5F clears it.
- R4: Accesses to offsets 0x58–0x5D change no flag, but they are flagged slow.
- R5: Writes to 0x00/0x01 set 80-store, writes to 0x0C/0x0D set 80-column and writes to 0x0E/0x0F set the alternate character set, each from address bit 0. Reads of these offsets leave every flag unchanged.
- R6: A read of a status offset returns the flag in bit 7 and 0 in bits 6:0. The offsets are 0x18 80-store, 0x1A text, 0x1B mixed, 0x1C page 2, 0x1D high resolution, 0x1E alternate character set and 0x1F 80-column.
- R7: A read of offset 0x19 returns vblank_i in bit 7.
- R8: A write to the memory-state offset 0x68 loads page 2 from write-data bit 6. This access is not flagged slow.
- R9: slow_o is 1 in the cycle of a valid access for three cases: any access to 0x50–0x5F, a write to 0x00/0x01/0x0C–0x0F, or a read of 0x18–0x1F. In every other case slow_o is 0.
- R10: Without valid_i, or for any address outside page C0 or outside the offsets above, no flag changes and rdata_o is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Access address |
| wr_i | input | 1 | 1 = write, 0 = read |
| valid_i | input | 1 | Access present this cycle |
| wdata_i | input | 8 | Write data (bit 6 used at the state offset) |
| vblank_i | input | 1 | Vertical-blank status from the video timing |
| rdata_o | output | 8 | Status read data |
| slow_o | output | 1 | Access needs the slow bus cycle |
| text_o | output | 1 | Text mode flag |
| mixed_o | output | 1 | Mixed mode flag |
| page2_o | output | 1 | Display page 2 flag |
| hires_o | output | 1 | High-resolution flag |
| an3_o | output | 1 | Annunciator 3 level |
| store80_o | output | 1 | 80-store flag |
| col80_o | output | 1 | 80-column flag |
| altchar_o | output | 1 | Alternate character set flag |

## Verification
The properties assume that an access lasts exactly one cycle, with address, strobe and data stable while valid_i is high. They also assume that rdata_o and slow_o are sampled in that same cycle, before the flag update. The bench drives each access for one cycle starting at the falling edge and samples the combinational outputs before the next rising edge. It sweeps every offset of page C0 in several orders, with both directions, varying data and vertical-blank levels. It also sweeps passes with valid_i toggling and a foreign page, so that each status read sees a different flag history.

// File: rtl/vmode_pkg.sv
package vmode_pkg;
  localparam int NUM_SW   = 8;
  localparam int SW_TEXT  = 0;
  localparam int SW_MIXED = 1;
  localparam int SW_PAGE2 = 2;
  localparam int SW_HIRES = 3;
  localparam int SW_AN3   = 4;
  localparam int SW_ST80  = 5;
  localparam int SW_COL80 = 6;
  localparam int SW_ALT   = 7;
  localparam int SEL_W    = 3;
endpackage

// File: rtl/vmode_decode.sv
module vmode_decode
  import vmode_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-9:0] IO_PAGE = 'hC0,
  parameter logic [7:0] STATE_LO = 8'h68
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              valid_i,
  input  logic              state_bit_i,
  output logic [NUM_SW-1:0] ld_en_o,
  output logic [NUM_SW-1:0] ld_val_o,
  output logic              slow_o,
  output logic              stat_hit_o,
  output logic [SEL_W-1:0]  stat_sel_o
);
  logic [7:0] lo;
  logic       io_hit;

  assign lo         = addr_i[7:0];
  assign io_hit     = valid_i && (addr_i[ADDR_W-1:8] == IO_PAGE);
  assign stat_sel_o = lo[SEL_W-1:0];

  always_comb begin
    ld_en_o    = '0;
    ld_val_o   = '0;
    slow_o     = 1'b0;
    stat_hit_o = 1'b0;
    if (io_hit) begin
      unique case (lo[7:3])
        5'b01010: begin // 0x50-0x57 any access
          slow_o = 1'b1;
          ld_en_o[int'(lo[2:1])]  = 1'b1;
          ld_val_o[int'(lo[2:1])] = lo[0];
        end
        5'b01011: begin // 0x58-0x5F, only the top pair latches
          slow_o = 1'b1;
          if (lo[2:1] == 2'b11) begin
            ld_en_o[SW_AN3]  = 1'b1;
            ld_val_o[SW_AN3] = ~lo[0];
          end
        end
        5'b00000: begin
          if (wr_i && lo[2:1] == 2'b00) begin
            slow_o = 1'b1;
            ld_en_o[SW_ST80]  = 1'b1;
            ld_val_o[SW_ST80] = lo[0];
          end
        end
        5'b00001: begin
          if (wr_i && lo[2]) begin
            slow_o = 1'b1;
            if (lo[1]) begin
              ld_en_o[SW_ALT]  = 1'b1;
              ld_val_o[SW_ALT] = lo[0];
            end else begin
              ld_en_o[SW_COL80]  = 1'b1;
              ld_val_o[SW_COL80] = lo[0];
            end
          end
        end
        5'b00011: begin // status window 0x18-0x1F
          if (!wr_i) begin
            slow_o     = 1'b1;
            stat_hit_o = 1'b1;
          end
        end
        default: ;
      endcase
      if (wr_i && lo == STATE_LO) begin
        ld_en_o[SW_PAGE2]  = 1'b1;
        ld_val_o[SW_PAGE2] = state_bit_i;
      end
    end
  end
endmodule

// File: rtl/vmode_latch.sv
module vmode_latch #(
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RESET_VAL;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/vmode_status.sv
module vmode_status
  import vmode_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [NUM_SW-1:0] sw_i,
  input  logic              vblank_i,
  input  logic              hit_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic flag;

  always_comb begin
    unique case (sel_i)
      3'd0: flag = sw_i[SW_ST80];
      3'd1: flag = vblank_i;
      3'd2: flag = sw_i[SW_TEXT];
      3'd3: flag = sw_i[SW_MIXED];
      3'd4: flag = sw_i[SW_PAGE2];
      3'd5: flag = sw_i[SW_HIRES];
      3'd6: flag = sw_i[SW_ALT];
      default: flag = sw_i[SW_COL80];
    endcase
  end

  assign rdata_o = hit_i ? {flag, {(DATA_W-1){1'b0}}} : '0;
endmodule

// File: rtl/vmode_switch_bank.sv
module vmode_switch_bank
  import vmode_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int PAGE_BIT = 6,
  parameter logic [ADDR_W-9:0] IO_PAGE = 'hC0,
  parameter logic [7:0] STATE_LO = 8'h68
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              vblank_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              slow_o,
  output logic              text_o,
  output logic              mixed_o,
  output logic              page2_o,
  output logic              hires_o,
  output logic              an3_o,
  output logic              store80_o,
  output logic              col80_o,
  output logic              altchar_o
);
  logic [NUM_SW-1:0] ld_en, ld_val, sw_q;
  logic              stat_hit;
  logic [SEL_W-1:0]  stat_sel;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i;

  vmode_decode #(
    .ADDR_W(ADDR_W), .IO_PAGE(IO_PAGE), .STATE_LO(STATE_LO)
  ) u_decode (
    .addr_i(addr_i), .wr_i(wr_i), .valid_i(valid_i),
    .state_bit_i(wdata_i[PAGE_BIT]),
    .ld_en_o(ld_en), .ld_val_o(ld_val), .slow_o(slow_o),
    .stat_hit_o(stat_hit), .stat_sel_o(stat_sel)
  );

  for (genvar g = 0; g < NUM_SW; g++) begin : g_sw
    vmode_latch #(.RESET_VAL(1'b0)) u_latch (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .en_i(ld_en[g]), .d_i(ld_val[g]), .q_o(sw_q[g])
    );
  end

  vmode_status #(.DATA_W(DATA_W)) u_status (
    .sw_i(sw_q), .vblank_i(vblank_i), .hit_i(stat_hit),
    .sel_i(stat_sel), .rdata_o(rdata_o)
  );

  assign text_o    = sw_q[SW_TEXT];
  assign mixed_o   = sw_q[SW_MIXED];
  assign page2_o   = sw_q[SW_PAGE2];
  assign hires_o   = sw_q[SW_HIRES];
  assign an3_o     = sw_q[SW_AN3];
  assign store80_o = sw_q[SW_ST80];
  assign col80_o   = sw_q[SW_COL80];
  assign altchar_o = sw_q[SW_ALT];

  // R2
  text_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && addr_i == {IO_PAGE, 8'h51} |=> text_o);
  // R3
  an3_inv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && addr_i == {IO_PAGE, 8'h5E} |=> an3_o);
  // R5
  wo_read_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !wr_i && addr_i == {IO_PAGE, 8'h0D} |=> $stable(col80_o));
  // R6
  rdata_low_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-2:0] == '0);
  // R9
  stat_slow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !wr_i && addr_i == {IO_PAGE, 8'h1C} |-> slow_o && rdata_o[DATA_W-1] == page2_o);
  // R8
  state_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && wr_i && addr_i == {IO_PAGE, STATE_LO} |=> page2_o == $past(wdata_i[PAGE_BIT]));
  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(sw_q));
endmodule

// File: tb/vmode_switch_bank_bench.sv
module vmode_switch_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        wr = 1'b0, valid = 1'b0, vb = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        slow, text, mixed, page2, hires, an3, st80, col80, alt;
  int checks = 0, fails = 0;
  bit done = 1'b0;
  // model order: text mixed page2 hires an3 st80 col80 alt
  logic [7:0] m;

  always #2 clk = ~clk;

  vmode_switch_bank u_vmode_switch_bank (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .valid_i(valid),
    .wdata_i(wdata), .vblank_i(vb), .rdata_o(rdata), .slow_o(slow),
    .text_o(text), .mixed_o(mixed), .page2_o(page2), .hires_o(hires),
    .an3_o(an3), .store80_o(st80), .col80_o(col80), .altchar_o(alt)
  );

  function automatic logic [7:0] outs();
    return {alt, col80, st80, an3, hires, page2, mixed, text};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s addr=%h wr=%0b act=%h exp=%h", tag, addr, wr, act, exp);
    end
  endtask

  function automatic bit io(input logic [15:0] a, input bit v);
    return v && a[15:8] == 8'hC0;
  endfunction

  function automatic bit exp_slow(input logic [15:0] a, input bit w, input bit v);
    logic [7:0] lo = a[7:0];
    if (!io(a, v)) return 1'b0;
    if (lo >= 8'h50 && lo <= 8'h5F) return 1'b1;
    if (w && (lo <= 8'h01 || (lo >= 8'h0C && lo <= 8'h0F))) return 1'b1;
    if (!w && lo >= 8'h18 && lo <= 8'h1F) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [15:0] a, input bit w, input bit v, input bit vbl);
    logic b;
    if (!io(a, v) || w || a[7:0] < 8'h18 || a[7:0] > 8'h1F) return 8'h00;
    case (a[7:0])
      8'h18: b = m[5];
      8'h19: b = vbl;
      8'h1A: b = m[0];
      8'h1B: b = m[1];
      8'h1C: b = m[2];
      8'h1D: b = m[3];
      8'h1E: b = m[7];
      default: b = m[6];
    endcase
    return b ? 8'h80 : 8'h00;
  endfunction

  function automatic string rd_tag(input logic [15:0] a, input bit w, input bit v);
    if (io(a, v) && !w && a[7:0] == 8'h19) return "R7";
    if (io(a, v) && !w && a[7:0] >= 8'h18 && a[7:0] <= 8'h1F) return "R6";
    return "R10";
  endfunction

  function automatic string sw_tag(input logic [15:0] a, input bit v);
    logic [7:0] lo = a[7:0];
    if (!io(a, v)) return "R10";
    if (lo >= 8'h50 && lo <= 8'h57) return "R2";
    if (lo == 8'h5E || lo == 8'h5F) return "R3";
    if (lo >= 8'h58 && lo <= 8'h5D) return "R4";
    if (lo <= 8'h0F) return "R5";
    if (lo == 8'h68) return "R8";
    return "R10";
  endfunction

  task automatic model_update(input logic [15:0] a, input bit w, input logic [7:0] d, input bit v);
    logic [7:0] lo = a[7:0];
    if (!io(a, v)) return;
    if (lo >= 8'h50 && lo <= 8'h57) m[(lo - 8'h50) >> 1] = lo[0];
    if (lo == 8'h5E || lo == 8'h5F) m[4] = ~lo[0];
    if (w && lo <= 8'h01) m[5] = lo[0];
    if (w && (lo == 8'h0C || lo == 8'h0D)) m[6] = lo[0];
    if (w && (lo == 8'h0E || lo == 8'h0F)) m[7] = lo[0];
    if (w && lo == 8'h68) m[2] = d[6];
  endtask

  task automatic acc(input logic [15:0] a, input bit w, input logic [7:0] d, input bit vbl, input bit v);
    @(negedge clk);
    addr = a; wr = w; wdata = d; vb = vbl; valid = v;
    #1;
    chk(rd_tag(a, w, v), rdata, exp_rd(a, w, v, vbl));
    chk("R9", {7'b0, slow}, {7'b0, exp_slow(a, w, v)});
    @(posedge clk);
    #1;
    model_update(a, w, d, v);
    chk(sw_tag(a, v), outs(), m);
  endtask

  initial begin
    repeat (500000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int strides[6] = '{1, 37, 101, 173, 7, 211};
    m = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", outs(), 8'h00);
    chk("R1", rdata, 8'h00);
    chk("R1", {7'b0, slow}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk("R1", outs(), 8'h00);
    // directed corners
    acc(16'hC051, 1'b0, 8'h00, 1'b0, 1'b1);  // R2 read sets text
    acc(16'hC01A, 1'b0, 8'h00, 1'b0, 1'b1);  // R6
    acc(16'hC05E, 1'b1, 8'h00, 1'b0, 1'b1);  // R3
    acc(16'hC00D, 1'b0, 8'h00, 1'b0, 1'b1);  // R5 read ignored
    acc(16'hC00D, 1'b1, 8'h00, 1'b0, 1'b1);  // R5 write sets
    acc(16'hC068, 1'b1, 8'h40, 1'b0, 1'b1);  // R8
    acc(16'hC01C, 1'b0, 8'h00, 1'b1, 1'b1);  // R6
    acc(16'hC019, 1'b0, 8'h00, 1'b1, 1'b1);  // R7
    acc(16'hC068, 1'b1, 8'hBF, 1'b0, 1'b1);  // R8 clear
    acc(16'hC05A, 1'b1, 8'hFF, 1'b0, 1'b1);  // R4
    acc(16'hC157, 1'b1, 8'hFF, 1'b0, 1'b1);  // R10 foreign page
    acc(16'hC050, 1'b1, 8'hFF, 1'b0, 1'b0);  // R10 no valid
    // sweeps
    for (int p = 0; p < 6; p++) begin
      for (int i = 0; i < 256; i++) begin
        for (int w = 0; w < 2; w++) begin
          logic [7:0] lo = 8'((i * strides[p] + p * 11) & 255);
          logic [15:0] a = {(p == 5) ? 8'hC4 : 8'hC0, lo};
          bit v = (p == 4) ? bit'(i[0] ^ w[0]) : 1'b1;
          acc(a, bit'(w[0] ^ p[0]), 8'(i * 13 + p), bit'(i[2]), v);
        end
      end
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule